// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block sits between a synchronous host and an asynchronous 4M x 4 fast page mode DRAM. The DRAM has no clock. The block drives the active-low row strobe, column strobe, write enable and output enable. It multiplexes the row and column halves of a 22-bit word address onto one shared address bus, and it drives or samples the 4-bit data lines. Every analog timing limit is given as a whole number of controller clock cycles, set through parameters.

After reset the controller waits for a power-up pause. It then runs a burst of refresh cycles that pulse the row strobe, and only after that does it offer service to the host. From then on, a timer asks for a column-before-row refresh at a fixed interval. A pending refresh always wins over host traffic, and any open row is closed first. The host port takes one request at a time. A request is accepted on a clock edge where `req` and `ready` are both high. Reads return data with a one-cycle `rvalid` pulse. A request that hits the row already open is served by a column cycle alone. A miss, a due refresh, or a row held open too long closes the row. The parameter `ROW_4K` selects between two device variants: 12 row and 10 column bits, or 11 row and 11 column bits.

Top module: `dfpm_ctl`

## Requirements
- R1: While reset is high, `ras_n`, `cas_n`, `we_n` and `oe_n` are high, and `ready`, `rvalid` and `dq_oe` are low.
- R2: After reset, `ras_n` does not fall for at least `T_INIT` cycles. `ready` stays low until at least `N_INIT` row-strobe pulses have been issued.
- R3: On a row-strobe fall for an access, `dram_addr` equals `req_addr[21:COL_W]`. On a column-strobe fall, `dram_addr` equals `req_addr[COL_W-1:0]` with zeros above it. `dram_addr` is held stable while `cas_n` is low. With `ROW_4K`=1, `COL_W` is 10 and the bus is 12 bits wide. With `ROW_4K`=0, `COL_W` is 11 and the bus is 11 bits wide.
- R4: For a write, `we_n` is low and `dq_oe` is high with `dq_out` equal to the accepted `req_wdata` in the cycle before `cas_n` falls, and they stay so while `cas_n` is low.
- R5: A read holds `we_n` high and drives `oe_n` low during the column cycle. It returns the word last written at that address (0 if never written) in `rdata`, with `rvalid` high for exactly one cycle.
- R6: A request to the row that is already open is served without `ras_n` rising.
- R7: A request to a different row raises `ras_n`, precharges, and reopens with the new row. The data stays correct.
- R8: A refresh drives `cas_n` low at least one cycle before `ras_n` falls. Refreshes keep recurring while the host is busy.
- R9: Consecutive refresh row-strobe falls are never more than `T_REFI + T_RAS_MAX + T_RCD + T_CAS + T_CP + T_RP + 10` cycles apart, even under back-to-back host requests.
- R10: Every `ras_n` low pulse lasts at least `T_RAS` cycles. Every `ras_n` high gap before a fall lasts at least `T_RP` cycles. `cas_n` is high for at least `T_CP` cycles before each column-strobe fall.
- R11: `ras_n` never stays low longer than `T_RAS_MAX + T_CAS + T_CP + 2` cycles. A long stream of same-row hits is split by extra row closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Host request valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address, row in upper bits |
| req_wdata | input | 4 | Write data |
| ready | output | 1 | Request accepted on this edge when `req` is high |
| rvalid | output | 1 | One-cycle read data strobe |
| rdata | output | 4 | Read data |
| ras_n | output | 1 | Row address strobe, active low |
| cas_n | output | 1 | Column address strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| dram_addr | output | ROW_W | Multiplexed row/column address |
| dq_out | output | 4 | Data toward the DRAM |
| dq_oe | output | 1 | Drive enable for `dq_out` |
| dq_in | input | 4 | Data from the DRAM |

## Verification
The hardest situations to reach from the ports are a row that expires while page hits keep arriving, and a refresh that falls due in the middle of a stream of requests. Both depend on internal counters that the host cannot see. The bench reaches the first by syncing to an observed refresh and then issuing a long chain of same-row reads whose total length exceeds the maximum open time. It reaches the second by sending several hundred back-to-back mixed requests over a few rows, so that refresh deadlines land in every phase of the access sequence. A behavioural DRAM model checks the strobe ordering and pulse lengths at every clock.

// File: rtl/dfpm_pkg.sv
package dfpm_pkg;
    localparam int WORD_W = 4;
    localparam int ADDR_W = 22;

    typedef enum logic [3:0] {
        S_PWR, S_REFC, S_REFR, S_PRE, S_IDLE,
        S_RSET, S_ROW, S_CSET, S_COL, S_CP, S_PAGE
    } st_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic oe_n;
    } strb_t;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } op_t;

    function automatic int row_bits(input bit four_k);
        return four_k ? 12 : 11;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Strobe levels implied by each sequencer state
    function automatic strb_t strobes(input st_e s, input logic wr);
        strb_t t;
        t = '1;
        case (s)
            S_REFC: t.cas_n = 1'b0;
            S_REFR: begin t.ras_n = 1'b0; t.cas_n = 1'b0; end
            S_ROW, S_CP, S_PAGE: t.ras_n = 1'b0;
            S_CSET: begin t.ras_n = 1'b0; t.we_n = ~wr; end
            S_COL: begin
                t.ras_n = 1'b0; t.cas_n = 1'b0;
                t.we_n  = ~wr;  t.oe_n  = wr;
            end
            default: t = '1;
        endcase
        return t;
    endfunction
endpackage

// File: rtl/dfpm_timer.sv
module dfpm_timer #(
    parameter int T_INIT = 10000,
    parameter int T_REFI = 780
) (
    input  logic clk,
    input  logic rst,
    input  logic take,
    output logic pwr_done,
    output logic ref_due
);
    localparam int PW = $clog2(T_INIT + 1);
    localparam int RW = $clog2(T_REFI + 1);

    logic [PW-1:0] pwr_cnt;
    logic [RW-1:0] ref_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            pwr_cnt  <= '0;
            pwr_done <= 1'b0;
        end else if (!pwr_done) begin
            if (pwr_cnt == PW'(T_INIT - 1)) pwr_done <= 1'b1;
            else                            pwr_cnt  <= pwr_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !pwr_done || take) begin
            ref_cnt <= '0;
            ref_due <= 1'b0;
        end else if (!ref_due) begin
            if (ref_cnt == RW'(T_REFI - 1)) ref_due <= 1'b1;
            else                            ref_cnt <= ref_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/dfpm_rowtrack.sv
module dfpm_rowtrack #(
    parameter int ROW_W     = 12,
    parameter int T_RAS     = 4,
    parameter int T_RAS_MAX = 500
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ras_low,
    input  logic             load,
    input  logic [ROW_W-1:0] load_row,
    input  logic [ROW_W-1:0] probe_row,
    output logic             hit,
    output logic             tras_met,
    output logic             expired
);
    localparam int AW = $clog2(T_RAS_MAX + 1);

    logic [ROW_W-1:0] open_row;
    logic [AW-1:0]    age_q;

    always_ff @(posedge clk) begin
        if (rst)       open_row <= '0;
        else if (load) open_row <= load_row;
    end

    // age_q counts completed low cycles before the current one
    always_ff @(posedge clk) begin
        if (rst || !ras_low)            age_q <= '0;
        else if (age_q != AW'(T_RAS_MAX)) age_q <= age_q + 1'b1;
    end

    assign hit      = (probe_row == open_row);
    assign tras_met = (age_q >= AW'(T_RAS - 1));
    assign expired  = (age_q >= AW'(T_RAS_MAX - 1));
endmodule

// File: rtl/dfpm_ctl.sv
module dfpm_ctl
    import dfpm_pkg::*;
#(
    parameter bit ROW_4K    = 1'b1,
    parameter int T_INIT    = 10000,
    parameter int N_INIT    = 8,
    parameter int T_REFI    = 780,
    parameter int T_RAS     = 4,
    parameter int T_RP      = 3,
    parameter int T_RCD     = 2,
    parameter int T_CAS     = 2,
    parameter int T_CP      = 1,
    parameter int T_RAS_MAX = 500,
    localparam int ROW_W    = row_bits(ROW_4K),
    localparam int COL_W    = ADDR_W - ROW_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              ready,
    output logic              rvalid,
    output logic [WORD_W-1:0] rdata,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              oe_n,
    output logic [ROW_W-1:0]  dram_addr,
    output logic [WORD_W-1:0] dq_out,
    output logic              dq_oe,
    input  logic [WORD_W-1:0] dq_in
);
    localparam int TMAX = max2(max2(max2(T_RAS, T_RP), max2(T_RCD, T_CAS)), T_CP);
    localparam int CW   = $clog2(TMAX + 1);
    localparam int IW   = $clog2(N_INIT + 1);

    st_e            st_q;
    logic [CW-1:0]  cnt_q;
    logic [IW-1:0]  init_left;
    logic           pend_q;
    op_t            op_q;
    strb_t          pins;
    logic           pwr_done, ref_due, hit, tras_met, expired;
    logic [ROW_W-1:0] op_row, req_row;
    logic [COL_W-1:0] op_col;

    assign op_row  = op_q.addr[ADDR_W-1 -: ROW_W];
    assign op_col  = op_q.addr[COL_W-1:0];
    assign req_row = req_addr[ADDR_W-1 -: ROW_W];

    dfpm_timer #(.T_INIT(T_INIT), .T_REFI(T_REFI)) u_timer (
        .clk(clk), .rst(rst), .take(st_q == S_REFC),
        .pwr_done(pwr_done), .ref_due(ref_due)
    );

    dfpm_rowtrack #(.ROW_W(ROW_W), .T_RAS(T_RAS), .T_RAS_MAX(T_RAS_MAX)) u_rows (
        .clk(clk), .rst(rst), .ras_low(!pins.ras_n), .load(st_q == S_RSET),
        .load_row(op_row), .probe_row(req_row),
        .hit(hit), .tras_met(tras_met), .expired(expired)
    );

    assign pins = strobes(st_q, op_q.we);
    assign ras_n = pins.ras_n;
    assign cas_n = pins.cas_n;
    assign we_n  = pins.we_n;
    assign oe_n  = pins.oe_n;
    assign dq_out = op_q.data;
    assign dq_oe  = op_q.we && (st_q == S_CSET || st_q == S_COL);

    assign ready = (st_q == S_IDLE && !ref_due) ||
                   (st_q == S_PAGE && !ref_due && !expired && !pend_q);

    always_comb begin
        case (st_q)
            S_RSET, S_ROW:              dram_addr = op_row;
            S_CSET, S_COL, S_CP, S_PAGE: dram_addr = {{(ROW_W-COL_W){1'b0}}, op_col};
            default:                    dram_addr = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= S_PWR;
            cnt_q     <= '0;
            init_left <= IW'(N_INIT);
            pend_q    <= 1'b0;
            op_q      <= '0;
            rvalid    <= 1'b0;
            rdata     <= '0;
        end else begin
            rvalid <= 1'b0;
            if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
            case (st_q)
                S_PWR:  if (pwr_done) st_q <= S_REFC;
                S_REFC: begin st_q <= S_REFR; cnt_q <= CW'(T_RAS - 1); end
                S_REFR: if (cnt_q == '0) begin
                    st_q  <= S_PRE;
                    cnt_q <= CW'(T_RP - 1);
                    if (init_left != '0) init_left <= init_left - 1'b1;
                end
                S_PRE: if (cnt_q == '0) begin
                    if (init_left != '0 || ref_due) st_q <= S_REFC;
                    else if (pend_q) begin st_q <= S_RSET; pend_q <= 1'b0; end
                    else st_q <= S_IDLE;
                end
                S_IDLE: begin
                    if (ref_due) st_q <= S_REFC;
                    else if (req) begin
                        op_q <= '{we: req_we, addr: req_addr, data: req_wdata};
                        st_q <= S_RSET;
                    end
                end
                S_RSET: begin st_q <= S_ROW; cnt_q <= CW'(T_RCD - 1); end
                S_ROW:  if (cnt_q == '0) st_q <= S_CSET;
                S_CSET: begin st_q <= S_COL; cnt_q <= CW'(T_CAS - 1); end
                S_COL: if (cnt_q == '0) begin
                    if (!op_q.we) begin rdata <= dq_in; rvalid <= 1'b1; end
                    st_q  <= S_CP;
                    cnt_q <= CW'(T_CP - 1);
                end
                S_CP: if (cnt_q == '0) st_q <= S_PAGE;
                S_PAGE: begin
                    if (pend_q || ref_due || expired) begin
                        if (tras_met) begin st_q <= S_PRE; cnt_q <= CW'(T_RP - 1); end
                    end else if (req) begin
                        op_q <= '{we: req_we, addr: req_addr, data: req_wdata};
                        if (hit) st_q <= S_CSET;
                        else     pend_q <= 1'b1;
                    end
                end
                default: st_q <= S_PWR;
            endcase
        end
    end

    // R8
    cbr_order_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(ras_n) && !cas_n) |-> !$past(cas_n));
    // R10
    ras_min_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n) |-> $past(tras_met));
    // R3
    col_addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!cas_n && !$past(cas_n)) |-> $stable(dram_addr));
    // R4
    wdata_setup_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(cas_n) && !we_n) |-> ($past(dq_oe) && !$past(we_n)));
    // R5
    rvalid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rvalid |=> !rvalid);
    // R2
    ready_init_chk: assert property (@(posedge clk) disable iff (rst)
        ready |-> (pwr_done && init_left == '0));
endmodule

// File: tb/test_dfpm_ctl.sv
module test_dfpm_ctl;
    localparam int T_INIT = 2000, N_INIT = 8, T_REFI = 780;
    localparam int T_RAS = 4, T_RP = 3, T_RCD = 2, T_CAS = 2, T_CP = 1, T_RAS_MAX = 60;
    localparam int GAP_MAX = T_REFI + T_RAS_MAX + T_RCD + T_CAS + T_CP + T_RP + 10;
    localparam int LOW_MAX = T_RAS_MAX + T_CAS + T_CP + 2;

    logic clk = 1'b0, rst = 1'b1;
    logic req = 1'b0, req_we = 1'b0;
    logic [21:0] req_addr = '0;
    logic [3:0] req_wdata = '0, rdata, dq_out;
    logic [3:0] dq_in = '0;
    logic ready, rvalid, ras_n, cas_n, we_n, oe_n, dq_oe;
    logic [11:0] dram_addr;

    always #10 clk = ~clk;

    dfpm_ctl #(.ROW_4K(1'b1), .T_INIT(T_INIT), .N_INIT(N_INIT), .T_REFI(T_REFI),
               .T_RAS(T_RAS), .T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS),
               .T_CP(T_CP), .T_RAS_MAX(T_RAS_MAX)) i_dfpm_ctl (
        .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .ready(ready), .rvalid(rvalid), .rdata(rdata),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
        .dram_addr(dram_addr), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in));

    int total = 0, bad = 0;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // Behavioural DRAM model and per-clock protocol monitor
    logic [3:0] mem [int];
    logic [3:0] shadow [int];
    int cyc = 0, nref = 0, nfall = 0, nrise = 0, last_ref = -1;
    int hi_len = 0, lo_len = 0, cas_hi = 0;
    bit prev_ras = 1'b1, prev_cas = 1'b1, ready_seen = 1'b0;
    logic [11:0] exp_row = '0, exp_col = '0, m_row = '0;
    logic [3:0] exp_wd = '0;

    always @(negedge clk) begin
        if (!rst) begin
            cyc++;
            if (prev_ras && !ras_n) begin
                nfall++;
                if (nfall > 1) chk(hi_len >= T_RP, "R10 precharge", hi_len, T_RP);
                else chk(cyc >= T_INIT, "R2 power-up pause", cyc, T_INIT);
                if (!cas_n) begin
                    chk(!prev_cas, "R8 cas before ras", prev_cas, 0);
                    if (last_ref >= 0) chk(cyc - last_ref <= GAP_MAX, "R9 refresh gap", cyc - last_ref, GAP_MAX);
                    last_ref = cyc;
                    nref++;
                end else begin
                    chk(dram_addr == exp_row, "R3 row address", dram_addr, exp_row);
                    m_row = dram_addr;
                end
            end
            if (!prev_ras && ras_n) begin
                nrise++;
                chk(lo_len >= T_RAS, "R10 ras low min", lo_len, T_RAS);
                chk(lo_len <= LOW_MAX, "R11 ras low max", lo_len, LOW_MAX);
            end
            if (!ras_n && !prev_ras && prev_cas && !cas_n) begin
                chk(cas_hi >= T_CP, "R10 cas precharge", cas_hi, T_CP);
                chk(dram_addr == exp_col, "R3 column address", dram_addr, exp_col);
                if (!we_n) begin
                    chk(dq_oe && dq_out == exp_wd, "R4 write data", dq_out, exp_wd);
                    mem[int'(m_row) * 4096 + int'(dram_addr)] = dq_out;
                end else begin
                    chk(!oe_n, "R5 output enable", oe_n, 0);
                    dq_in = mem.exists(int'(m_row) * 4096 + int'(dram_addr)) ?
                            mem[int'(m_row) * 4096 + int'(dram_addr)] : 4'h0;
                end
            end
            if (ready && !ready_seen) begin
                ready_seen = 1'b1;
                chk(nfall >= N_INIT, "R2 init pulses", nfall, N_INIT);
            end
            if (ras_n) begin hi_len = prev_ras ? hi_len + 1 : 1; lo_len = 0; end
            else begin lo_len = prev_ras ? 1 : lo_len + 1; hi_len = 0; end
            cas_hi = cas_n ? (prev_cas ? cas_hi + 1 : 1) : 0;
            prev_ras = ras_n;
            prev_cas = cas_n;
        end
    end

    task automatic host_op(input logic w, input logic [21:0] a, input logic [3:0] d);
        logic [3:0] e;
        @(negedge clk);
        req = 1'b1; req_we = w; req_addr = a; req_wdata = d;
        while (!ready) @(negedge clk);
        exp_row = a[21:10];
        exp_col = {2'b00, a[9:0]};
        exp_wd  = d;
        @(negedge clk);
        req = 1'b0;
        if (w) shadow[int'(a)] = d;
        else begin
            e = shadow.exists(int'(a)) ? shadow[int'(a)] : 4'h0;
            while (!rvalid) @(negedge clk);
            chk(rdata == e, "R5 read data", rdata, e);
            @(negedge clk);
            chk(!rvalid, "R5 rvalid pulse", rvalid, 0);
        end
    endtask

    task automatic wait_ref();
        int n;
        n = nref;
        while (nref == n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int rb, n0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(ras_n && cas_n && we_n && oe_n, "R1 strobes", {ras_n, cas_n, we_n, oe_n}, 15);
        chk(!ready && !rvalid && !dq_oe, "R1 outputs", {ready, rvalid, dq_oe}, 0);
        rst = 1'b0;
        while (!ready) @(negedge clk);

        for (int i = 0; i < 16; i++)
            host_op(1'b1, 22'((i * 22'h1357B + 22'h0A5) & 22'h3FFFFF), 4'(i ^ 9));
        for (int i = 0; i < 16; i++)
            host_op(1'b0, 22'((i * 22'h1357B + 22'h0A5) & 22'h3FFFFF), 4'h0);

        // R6 page hit
        wait_ref();
        host_op(1'b1, {12'h2A5, 10'h011}, 4'h6);
        host_op(1'b1, {12'h2A5, 10'h3F0}, 4'hB);
        rb = nrise;
        host_op(1'b0, {12'h2A5, 10'h011}, 4'h0);
        host_op(1'b0, {12'h2A5, 10'h3F0}, 4'h0);
        chk(nrise == rb, "R6 no row close on hit", nrise - rb, 0);

        // R7 row miss
        rb = nrise;
        host_op(1'b0, {12'h801, 10'h001}, 4'h0);
        chk(nrise > rb, "R7 row closed on miss", nrise - rb, 1);
        host_op(1'b0, {12'h2A5, 10'h011}, 4'h0);

        // R11 long same-row stream
        wait_ref();
        rb = nrise;
        for (int i = 0; i < 40; i++) host_op(1'b0, {12'h0F3, 10'(i * 3)}, 4'h0);
        chk(nrise - rb >= 2, "R11 forced closes", nrise - rb, 2);

        // R8/R9 continuous mixed load across refresh deadlines
        n0 = nref;
        for (int i = 0; i < 400; i++)
            host_op((i % 3) != 2, {12'(5 + i % 3), 10'(i * 7)}, 4'(i));
        chk(nref - n0 >= 3, "R8 refresh under load", nref - n0, 3);

        repeat (5) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule